// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a serial peripheral interface master that sits on a simple word-addressed register bus. Software loads outgoing words into a 64-entry transmit queue. It chooses one of four peripheral select lines and a word length, and writes a start bit in the control register. The controller then sends every queued word back to back, most significant bit first. While it sends, it samples the input line, and each received word lands in a 64-entry receive queue. Software drains that queue by reading one data register repeatedly.

The serial clock comes from two cascaded dividers. A linear prescaler divides by 1 to 16, and a power-of-two stage divides by 2^0 to 2^15. Each select line has its own clock phase, idle clock level, select polarity and hold-between-words setting. An interrupt line combines "transmit queue empty" and "receive data ready", each gated by its own enable bit.

Register word addresses, on `busWordAddr`, are: 0 receive data (a read pops), 1 transmit data (a write pushes), 2 control, 3 per-select configuration, 4 interrupt enable, 5 status.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset every register reads 0 except status, which reads 0x01. `sclk` is 0, `irq` is 0, and every select line sits at its inactive level. Select line n is inactive at the inverse of configuration bit n+12, so all four read 1 after reset.
- R2: A write to address 1 pushes a word into the transmit queue. Status bit 0 is 1 while that queue is empty, and status bit 1 is 1 while it holds 64 words. A push to a full queue is dropped.
- R3: A read of address 0 returns the oldest received word and removes it. Status bit 3 is 1 while the receive queue holds at least one word. A read while that queue is empty returns 0 and changes nothing.
- R4: Control bit 0 enables the block, and control bits 7:4 give master mode for selects 0 to 3. Writing 1 to control bit 2 requests a burst. The request stays pending, and nothing is sent, until bit 0 is set and the master bit of the chosen select is set. Writing 0 to bit 2 does not cancel the request.
- R5: A burst sends every word in the transmit queue, and each sent word puts exactly one word into the receive queue. Control bit 2 reads 1 until the last word has finished, then reads 0.
- R6: A word has (control bits 31:20) + 1 bits, limited to 32. It goes out on `mosi` most significant bit first. Received bits are right-aligned in the received word.
- R7: Each half period of `sclk` lasts (P+1)·2^Q module clocks, where P is control bits 15:12 and Q is control bits 11:8.
- R8: For select n, configuration bit n+4 is the idle `sclk` level. Configuration bit n sets the phase. With bit n clear, `miso` is sampled on the leading edge and `mosi` changes on the trailing edge. With bit n set, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R9: Control bits 19:18 choose the select line. During a burst that line is driven to its active level, configuration bit n+12, where 1 means active high. All other lines stay at their inactive level, and at most one line is ever active.
- R10: When configuration bit n+8 is 1, the select stays active across the whole burst. When it is 0, the select goes inactive for one half period between consecutive words. The select always goes inactive when the burst ends.
- R11: `irq` is 1 when either (interrupt-enable bit 0 is set and the transmit queue is empty) or (interrupt-enable bit 3 is set and the receive queue is non-empty).
- R12: If a word completes while the receive queue is full, that word is dropped and status bit 7 is set. Bit 7 stays set until software writes 1 to status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busWordAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csLines | output | 4 | Peripheral select lines |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that ends the access. Read data is combinational within the access cycle, and a pop happens at that same edge. Once a start request is accepted, the select becomes active two edges later. The first `sclk` toggle follows one full divider period after that, and every later toggle follows one divider period after the previous one. The start bit clears one edge after the word-end cycle of the last word.

The bench drives inputs on falling edges and samples just after them. It measures the `sclk` half period by counting clocks between toggles. Instead of assuming a burst length, it polls the start bit for the end of the burst, and it checks queue contents, select levels and status only after that bit has cleared or at fixed mid-burst offsets.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int NUM_CS = 4;
  localparam int BUS_W  = 32;
  localparam int DIV_W  = 20;

  localparam logic [2:0] IDX_RXDATA = 3'd0;
  localparam logic [2:0] IDX_TXDATA = 3'd1;
  localparam logic [2:0] IDX_CTRL   = 3'd2;
  localparam logic [2:0] IDX_CFG    = 3'd3;
  localparam logic [2:0] IDX_IRQEN  = 3'd4;
  localparam logic [2:0] IDX_STATUS = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_WEND, ST_GAP
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic load;
    logic prime;
    logic shiftOut;
    logic sampleIn;
  } dpStrobe_t;
endpackage

// File: rtl/spi_fifo_queue.sv
module spi_fifo_queue #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == (AW+1)'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R2: occupancy never exceeds the depth
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= (AW+1)'(DEPTH));
  // R3: popping the only word leaves the queue empty
  assert_last_pop_empties_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && count == (AW+1)'(1)) |=> empty);
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int BITS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] txWord,
  input  logic [BITS_W-1:0] wordBits,
  input  logic              misoIn,
  output logic              mosiOut,
  output logic [DATA_W-1:0] rxWord,
  output logic              txEmpty,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              rxFull
);
  logic [DATA_W-1:0] txHead, txShift, rxShift, aligned;
  logic [BITS_W-1:0] shAmt;

  assign shAmt   = BITS_W'(DATA_W) - wordBits;
  assign aligned = txHead << shAmt;

  spi_fifo_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txQ (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pop(strobe.txPop),
    .wdata(txWord), .rdata(txHead), .empty(txEmpty), .full(txFull));

  spi_fifo_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .push(strobe.rxPush), .pop(strobe.rxPop),
    .wdata(rxShift), .rdata(rxWord), .empty(rxEmpty), .full(rxFull));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosiOut <= 1'b0;
    end else if (strobe.load) begin
      rxShift <= '0;
      if (strobe.prime) begin
        mosiOut <= aligned[DATA_W-1];
        txShift <= aligned << 1;
      end else begin
        txShift <= aligned;
      end
    end else begin
      if (strobe.shiftOut) begin
        mosiOut <= txShift[DATA_W-1];
        txShift <= txShift << 1;
      end
      if (strobe.sampleIn) rxShift <= {rxShift[DATA_W-2:0], misoIn};
    end
  end

  // R5: the sequencer only loads when a word is queued
  assert_load_has_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !txEmpty);
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BITS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [2:0]        busWordAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              txEmpty,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic              rxFull,
  input  logic [DATA_W-1:0] rxWord,
  output dpStrobe_t         strobe,
  output logic [BITS_W-1:0] wordBits,
  output logic              sclk,
  output logic [NUM_CS-1:0] csLines,
  output logic              irq
);
  localparam int EDGE_W = BITS_W + 1;

  seqState_t         state;
  logic [BUS_W-1:0]  ctrlReg;
  logic [15:0]       cfgReg;
  logic              xch, ieTx, ieRx, ovf, csOn, sclkPhase;
  logic [EDGE_W-1:0] edgeCnt;
  logic [DIV_W-1:0]  divCnt, divLimit;
  logic [1:0]        csSel;
  logic              cpha, cpol, holdSel, start, tick, lastEdge, leading;
  logic              wrEn, rdEn, ovfClr;

  assign wrEn   = busSel && busWrite;
  assign rdEn   = busSel && !busWrite;
  assign ovfClr = wrEn && busWordAddr == IDX_STATUS && busWdata[7];

  assign csSel    = ctrlReg[19:18];
  assign cpha     = cfgReg[csSel];
  assign cpol     = cfgReg[4 + csSel];
  assign holdSel  = cfgReg[8 + csSel];
  assign start    = xch && ctrlReg[0] && ctrlReg[4 + csSel];
  assign wordBits = (ctrlReg[31:20] >= 12'(DATA_W)) ? BITS_W'(DATA_W)
                                                   : BITS_W'(ctrlReg[31:20]) + BITS_W'(1);
  assign divLimit = (DIV_W'(ctrlReg[15:12]) + DIV_W'(1)) << ctrlReg[11:8];
  assign tick     = (divCnt == divLimit - DIV_W'(1));
  assign lastEdge = (edgeCnt == {wordBits, 1'b0} - EDGE_W'(1));
  assign leading  = !edgeCnt[0];

  assign sclk = sclkPhase ^ cpol;
  assign irq  = (ieTx && txEmpty) || (ieRx && !rxEmpty);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csLines[i] = (csOn && csSel == 2'(i)) ? cfgReg[12 + i] : !cfgReg[12 + i];
  end

  always_comb begin
    strobe        = '0;
    strobe.txPush = wrEn && busWordAddr == IDX_TXDATA;
    strobe.rxPop  = rdEn && busWordAddr == IDX_RXDATA;
    case (state)
      ST_LOAD: begin
        strobe.txPop = 1'b1;
        strobe.load  = 1'b1;
        strobe.prime = !cpha;
      end
      ST_SHIFT: if (tick) begin
        strobe.shiftOut = (leading == cpha);
        strobe.sampleIn = (leading != cpha);
      end
      ST_WEND: strobe.rxPush = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (busWordAddr)
      IDX_RXDATA: busRdata = rxEmpty ? '0 : BUS_W'(rxWord);
      IDX_CTRL:   busRdata = {ctrlReg[31:3], xch, ctrlReg[1:0]};
      IDX_CFG:    busRdata = {16'b0, cfgReg};
      IDX_IRQEN:  busRdata = {28'b0, ieRx, 2'b0, ieTx};
      IDX_STATUS: busRdata = {24'b0, ovf, 3'b0, !rxEmpty, 1'b0, txFull, txEmpty};
      default:    busRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ctrlReg   <= '0;
      cfgReg    <= '0;
      xch       <= 1'b0;
      ieTx      <= 1'b0;
      ieRx      <= 1'b0;
      ovf       <= 1'b0;
      csOn      <= 1'b0;
      sclkPhase <= 1'b0;
      edgeCnt   <= '0;
      divCnt    <= '0;
    end else begin
      if (wrEn && busWordAddr == IDX_CTRL) begin
        ctrlReg <= busWdata;
        xch     <= xch || busWdata[2];
      end
      if (wrEn && busWordAddr == IDX_CFG) cfgReg <= busWdata[15:0];
      if (wrEn && busWordAddr == IDX_IRQEN) begin
        ieTx <= busWdata[0];
        ieRx <= busWdata[3];
      end
      if (ovfClr) ovf <= 1'b0;

      case (state)
        ST_IDLE: if (start) begin
          if (txEmpty) xch <= 1'b0;
          else         state <= ST_LOAD;
        end
        ST_LOAD: begin
          csOn    <= 1'b1;
          edgeCnt <= '0;
          divCnt  <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt    <= '0;
            sclkPhase <= !sclkPhase;
            edgeCnt   <= edgeCnt + EDGE_W'(1);
            if (lastEdge) state <= ST_WEND;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_WEND: begin
          if (rxFull) ovf <= 1'b1;
          if (txEmpty) begin
            xch   <= 1'b0;
            csOn  <= 1'b0;
            state <= ST_IDLE;
          end else if (holdSel) begin
            state <= ST_LOAD;
          end else begin
            csOn   <= 1'b0;
            divCnt <= '0;
            state  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) state <= ST_LOAD;
          else      divCnt <= divCnt + DIV_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a burst in progress keeps the request bit set
  assert_busy_holds_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> xch);
  // R8: between bursts the clock rests at its idle level
  assert_clock_idle_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (sclk == cpol));
  // R9: at most one select line at its active level
  assert_single_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csLines ^ ~cfgReg[15:12]));
  // R12: the overrun flag is sticky until cleared
  assert_overrun_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !ovfClr) |=> ovf);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [2:0]  busWordAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  csLines,
  output logic        irq
);
  localparam int BITS_W = $clog2(DATA_W + 1);

  dpStrobe_t         strobe;
  logic [BITS_W-1:0] wordBits;
  logic [DATA_W-1:0] rxWord;
  logic              txEmpty, txFull, rxEmpty, rxFull;

  spi_fifo_ctrl #(.DATA_W(DATA_W), .BITS_W(BITS_W)) ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .rxWord(rxWord), .strobe(strobe), .wordBits(wordBits), .sclk(sclk),
    .csLines(csLines), .irq(irq));

  spi_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BITS_W(BITS_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(DATA_W'(busWdata)),
    .wordBits(wordBits), .misoIn(miso), .mosiOut(mosi), .rxWord(rxWord),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull));
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [2:0]  busWordAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sclk, mosi, miso;
  logic [3:0]  csLines;
  logic        irq;

  int  checks = 0, failures = 0;
  bit  invertMiso = 1'b0, capEnable = 1'b0, cpolB = 1'b0, cphaB = 1'b0;
  logic [63:0] capBits = '0;
  int  cycCount = 0, lastEdgeCyc = 0, lastGap = 0;
  int  rise0 = 0, rise1 = 0;

  always #10 clk = ~clk;

  spi_fifo_master dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csLines(csLines), .irq(irq));

  assign miso = invertMiso ? ~mosi : mosi;

  always @(posedge clk) cycCount <= cycCount + 1;

  // peripheral model: record mosi on the sampling edge of the chosen mode
  always @(sclk) begin
    lastGap     = cycCount - lastEdgeCyc;
    lastEdgeCyc = cycCount;
    if (capEnable && (((sclk != cpolB) ? 1'b1 : 1'b0) ^ cphaB))
      capBits = {capBits[62:0], mosi};
  end

  always @(posedge csLines[0]) rise0++;
  always @(posedge csLines[1]) rise1++;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busWordAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busWordAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitBurst(input string tag);
    logic [31:0] v;
    v = 32'h4;
    for (int i = 0; i < 20000 && v[2]; i++) busRd(3'd2, v);
    check(!v[2], tag, {63'b0, v[2]}, 64'h0);
  endtask

  task automatic printSummary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      busRd(3'(a), v);
      check(v == 0, "R1 register reset value", {32'b0, v}, 64'h0);
    end
    busRd(3'd5, v);
    check(v == 32'h1, "R1 status reset value", {32'b0, v}, 64'h1);
    check(csLines == 4'hF && sclk == 1'b0 && irq == 1'b0, "R1 outputs after reset",
          {58'b0, csLines, sclk, irq}, {58'b0, 4'hF, 1'b0, 1'b0});
  endtask

  task automatic testBasicBurst();
    logic [31:0] v;
    busWr(3'd4, 32'h9);
    check(irq == 1'b1, "R11 irq on empty transmit queue", {63'b0, irq}, 64'h1);
    busWr(3'd4, 32'h8);
    check(irq == 1'b0, "R11 irq masked, receive empty", {63'b0, irq}, 64'h0);
    busWr(3'd3, 32'h100);
    busWr(3'd2, 32'h007000F1);
    busWr(3'd1, 32'hA5);
    busWr(3'd1, 32'h3C);
    cpolB = 0; cphaB = 0; invertMiso = 0; capBits = '0; capEnable = 1; rise0 = 0;
    busWr(3'd2, 32'h007000F5);
    repeat (5) @(negedge clk);
    check(csLines == 4'hE, "R9 select 0 active low mid-burst", {60'b0, csLines}, 64'hE);
    waitBurst("R5 request clears after burst");
    capEnable = 0;
    check(capBits[15:0] == 16'hA53C, "R6 msb-first order on mosi", {48'b0, capBits[15:0]}, 64'hA53C);
    check(rise0 == 1, "R10 select held across burst", 64'(rise0), 64'd1);
    check(irq == 1'b1, "R11 irq on receive ready", {63'b0, irq}, 64'h1);
    busRd(3'd0, v);
    check(v == 32'hA5, "R5 first received word", {32'b0, v}, 64'hA5);
    busRd(3'd0, v);
    check(v == 32'h3C, "R5 second received word", {32'b0, v}, 64'h3C);
    busRd(3'd5, v);
    check(v[3] == 1'b0, "R3 ready clears after drain", {63'b0, v[3]}, 64'h0);
    busRd(3'd0, v);
    check(v == 0, "R3 read of empty queue", {32'b0, v}, 64'h0);
    busRd(3'd5, v);
    check(v == 32'h1, "R3 empty read changes nothing", {32'b0, v}, 64'h1);
    busWr(3'd4, 32'h0);
  endtask

  task automatic testModeDivider();
    logic [31:0] v;
    cpolB = 1; cphaB = 1; invertMiso = 1;
    busWr(3'd3, 32'h4444);
    busWr(3'd2, 32'h00B821F1);
    check(sclk == 1'b1 && csLines == 4'hB, "R8 R9 idle clock high, select 2 inactive low",
          {59'b0, sclk, csLines}, {59'b0, 1'b1, 4'hB});
    busWr(3'd1, 32'hABC);
    busWr(3'd1, 32'h123);
    capBits = '0; capEnable = 1;
    busWr(3'd2, 32'h00B821F5);
    repeat (10) @(negedge clk);
    check(csLines == 4'hF, "R9 select 2 active high mid-burst", {60'b0, csLines}, 64'hF);
    waitBurst("R5 request clears after mode burst");
    capEnable = 0;
    check(capBits[23:0] == 24'hABC123, "R6 R8 12-bit words, phase 1", {40'b0, capBits[23:0]}, 64'hABC123);
    check(lastGap == 6, "R7 half period (2+1)*2^1", 64'(lastGap), 64'd6);
    check(sclk == 1'b1, "R8 clock back at idle high", {63'b0, sclk}, 64'h1);
    busRd(3'd0, v);
    check(v == 32'h543, "R6 right-aligned receive word 0", {32'b0, v}, 64'h543);
    busRd(3'd0, v);
    check(v == 32'hEDC, "R6 right-aligned receive word 1", {32'b0, v}, 64'hEDC);
    invertMiso = 0; cpolB = 0; cphaB = 0;
  endtask

  task automatic testGap();
    logic [31:0] v;
    busWr(3'd3, 32'h0);
    busWr(3'd2, 32'h007400F1);
    busWr(3'd1, 32'h11);
    busWr(3'd1, 32'h22);
    rise1 = 0;
    busWr(3'd2, 32'h007400F5);
    waitBurst("R5 request clears after gap burst");
    check(rise1 == 2, "R10 select released between words", 64'(rise1), 64'd2);
    check(csLines == 4'hF, "R10 select inactive after burst", {60'b0, csLines}, 64'hF);
    busRd(3'd0, v);
    busRd(3'd0, v);
    check(v == 32'h22, "R10 second word intact", {32'b0, v}, 64'h22);
  endtask

  task automatic testGating();
    logic [31:0] v;
    busWr(3'd3, 32'h100);
    busWr(3'd1, 32'h5A);
    busWr(3'd2, 32'h007000F4);
    repeat (40) @(negedge clk);
    busRd(3'd2, v);
    check(v[2] == 1'b1, "R4 request pending while disabled", {63'b0, v[2]}, 64'h1);
    busWr(3'd2, 32'h00700001);
    repeat (40) @(negedge clk);
    busRd(3'd5, v);
    check(v[3:0] == 4'h0, "R4 no transfer without master bit", {60'b0, v[3:0]}, 64'h0);
    busWr(3'd2, 32'h007000F1);
    waitBurst("R4 pending request runs once allowed");
    busRd(3'd0, v);
    check(v == 32'h5A, "R4 word sent after enabling", {32'b0, v}, 64'h5A);
  endtask

  task automatic testFullQueues();
    logic [31:0] v;
    busWr(3'd2, 32'h007000F1);
    for (int k = 0; k < 65; k++) busWr(3'd1, 32'(k));
    busRd(3'd5, v);
    check(v[1:0] == 2'b10, "R2 transmit full flag", {62'b0, v[1:0]}, 64'h2);
    busWr(3'd4, 32'h1);
    check(irq == 1'b0, "R11 no irq with queued words", {63'b0, irq}, 64'h0);
    busWr(3'd4, 32'h0);
    busWr(3'd2, 32'h007000F5);
    waitBurst("R5 request clears after full burst");
    for (int k = 0; k < 64; k++) busRd(3'd0, v);
    check(v == 32'd63, "R2 push to full queue dropped", {32'b0, v}, 64'd63);
    busRd(3'd5, v);
    check(v[7] == 1'b0 && v[3] == 1'b0, "R2 exactly 64 words, no overrun", {56'b0, v[7:0]}, 64'h1);
    for (int k = 0; k < 64; k++) busWr(3'd1, 32'(k + 100));
    busWr(3'd2, 32'h007000F5);
    waitBurst("R12 first filling burst");
    busWr(3'd1, 32'h77);
    busWr(3'd2, 32'h007000F5);
    waitBurst("R12 overflowing burst");
    busRd(3'd5, v);
    check(v[7] == 1'b1, "R12 overrun flag set", {63'b0, v[7]}, 64'h1);
    busRd(3'd0, v);
    check(v == 32'd100, "R12 oldest word kept", {32'b0, v}, 64'd100);
    busRd(3'd5, v);
    check(v[7] == 1'b1, "R12 flag sticky after read", {63'b0, v[7]}, 64'h1);
    busWr(3'd5, 32'h80);
    busRd(3'd5, v);
    check(v[7] == 1'b0, "R12 flag cleared by write", {63'b0, v[7]}, 64'h0);
    for (int k = 1; k < 64; k++) busRd(3'd0, v);
    check(v == 32'd163, "R12 overflowing word dropped", {32'b0, v}, 64'd163);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R5 watchdog expired actual=0x0 expected=0x1");
    printSummary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicBurst();
    testModeDivider();
    testGap();
    testGating();
    testFullQueues();
    printSummary();
    $finish;
  end
endmodule